// File: doc/BRIEF.md
# DRAM Range Router with Node Interleave

This block maps each DRAM request to the node that owns its 40-bit physical address. It holds eight programmable address windows. Each window is made of a base word and a limit word that software writes through a small register port. A request carries an address, a read/write type and a valid strobe. One cycle later the router answers with a hit or a miss and, on a hit, a 3-bit destination node.

A window's bounds cover address bits 39:24, so windows are sized in steps of 16 MB. Reads and writes are enabled separately for each window. A window can also take part in node interleaving. In that case the window answers only when selected bits among A[14:12] equal a select value stored in its limit word. Several windows can then cover the same span, each owning one interleave slice. When more than one window matches, the lowest-numbered window wins. Software writes a window's limit word before its base word, because the base word carries the enables.

Top module: `dram_range_router`

## Requirements
- R1: After synchronous reset, every base and limit word reads back as zero, `rsp_valid`, `rsp_hit` and `rsp_miss` are low, and `rsp_node` is zero.
- R2: Window i has its base word at byte offset 0x40+8*i and its limit word at 0x44+8*i. Address bits 1:0 are ignored. Writable base bits are 0 (read enable), 1 (write enable), 10:8 (interleave code) and 31:16 (lower bound, A[39:24]). Writable limit bits are 2:0 (node), 10:8 (interleave select) and 31:16 (upper bound). All other bits read zero whatever was written. `cfg_rdata` shows the word at `cfg_addr` one cycle after the address is presented.
- R3: A window matches when A[39:24] is at least its lower bound and at most its upper bound. Both bounds are inclusive.
- R4: A read matches a window only if that window's base bit 0 is set. A write matches only if base bit 1 is set.
- R5: The interleave code selects which bits of A[14:12] must equal the same bits of the select field. Code 000 selects none. Code 001 selects A[12]. Code 011 selects A[12] and A[14]. Code 111 selects all three bits. The reserved codes (010, 100, 101, 110) select none.
- R6: When several windows match, the response uses the lowest-numbered window.
- R7: Each response appears exactly one cycle after the request, with `rsp_valid` high and exactly one of `rsp_hit` and `rsp_miss` high. On a miss, `rsp_node` is zero. With no request, `rsp_valid`, `rsp_hit` and `rsp_miss` are low.
- R8: On a hit, `rsp_node` equals bits 2:0 of the winning window's limit word.
- R9: Register writes outside offsets 0x40 to 0x7F change no window, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's `cfg_addr` |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 40 | Physical request address |
| rsp_valid | output | 1 | Response present, one cycle after `req_valid` |
| rsp_hit | output | 1 | The request matched a window |
| rsp_miss | output | 1 | The request matched no window |
| rsp_node | output | 3 | Destination node, zero on a miss |

## Verification
The bound checker watches the response framing on every cycle. It checks the one-cycle response timing, that hit and miss are exclusive, that the node is zero on a miss, and that outputs are quiet after reset. On every read-back it also checks that reserved bits are zero and that reads outside the register window return zero. Those assertions cannot see window contents. Inclusive bounds, the read and write enables, each interleave code and the lowest-index priority can only be shown by the bench's programmed windows and its table of addresses with expected owners.

// File: rtl/dram_rr_pkg.sv
package dram_rr_pkg;
  localparam int NODE_W = 3;
  localparam int ILV_W  = 3;
  localparam int BND_W  = 16;
  localparam int BND_LO = 24;

  // writable bits of each word, all others read zero
  localparam logic [31:0] BASE_WMASK = 32'hFFFF_0703;
  localparam logic [31:0] LIM_WMASK  = 32'hFFFF_0707;

  typedef logic [NODE_W-1:0] node_t;

  // which of A[14:12] take part in the interleave compare
  function automatic logic [ILV_W-1:0] ilv_mask(input logic [ILV_W-1:0] code);
    case (code)
      3'b001:  ilv_mask = 3'b001;
      3'b011:  ilv_mask = 3'b101;
      3'b111:  ilv_mask = 3'b111;
      default: ilv_mask = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/dram_rr_regfile.sv
module dram_rr_regfile
  import dram_rr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int CFG_AW     = 8,
  parameter int REG_BASE   = 'h40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  output logic [NUM_RANGES-1:0][31:0]  base_o,
  output logic [NUM_RANGES-1:0][31:0]  lim_o
);
  localparam int IDX_W = $clog2(NUM_RANGES);
  localparam logic [CFG_AW:0] WIN_LO = (CFG_AW+1)'(REG_BASE);
  localparam logic [CFG_AW:0] WIN_HI = (CFG_AW+1)'(REG_BASE + NUM_RANGES*8);

  logic [CFG_AW-1:0] off;
  logic              in_win;
  logic [IDX_W-1:0]  idx;
  logic              is_lim;

  assign off    = cfg_addr - WIN_LO[CFG_AW-1:0];
  assign in_win = ({1'b0, cfg_addr} >= WIN_LO) && ({1'b0, cfg_addr} < WIN_HI);
  assign idx    = off[IDX_W+2:3];
  assign is_lim = off[2];

  logic unused_off;
  assign unused_off = ^{off[1:0], off[CFG_AW-1:IDX_W+3]};

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[g] <= '0;
        lim_o[g]  <= '0;
      end else if (cfg_we && in_win && idx == IDX_W'(g)) begin
        if (is_lim) lim_o[g]  <= cfg_wdata & LIM_WMASK;
        else        base_o[g] <= cfg_wdata & BASE_WMASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cfg_rdata <= '0;
    else if (!in_win) cfg_rdata <= '0;
    else if (is_lim)  cfg_rdata <= lim_o[idx];
    else              cfg_rdata <= base_o[idx];
  end
endmodule

// File: rtl/dram_rr_match.sv
module dram_rr_match
  import dram_rr_pkg::*;
(
  input  logic [31:0]      base_w,
  input  logic [31:0]      lim_w,
  input  logic [BND_W-1:0] addr_hi,
  input  logic [ILV_W-1:0] addr_ilv,
  input  logic             is_write,
  output logic             hit
);
  logic             in_span;
  logic             enabled;
  logic [ILV_W-1:0] sel_mask;
  logic             ilv_ok;

  assign in_span  = (addr_hi >= base_w[31:16]) && (addr_hi <= lim_w[31:16]);
  assign enabled  = is_write ? base_w[1] : base_w[0];
  assign sel_mask = ilv_mask(base_w[10:8]);
  assign ilv_ok   = ((addr_ilv ^ lim_w[10:8]) & sel_mask) == '0;
  assign hit      = in_span && enabled && ilv_ok;

  logic unused_fields;
  assign unused_fields = ^{base_w[15:11], base_w[7:2], lim_w[15:11], lim_w[7:0]};
endmodule

// File: rtl/dram_rr_prio.sv
module dram_rr_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dram_range_router.sv
module dram_range_router
  import dram_rr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int CFG_AW     = 8,
  parameter int REG_BASE   = 'h40,
  parameter int PA_W       = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PA_W-1:0]   req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [NODE_W-1:0] rsp_node
);
  localparam int IDX_W = $clog2(NUM_RANGES);

  logic [NUM_RANGES-1:0][31:0] base_w;
  logic [NUM_RANGES-1:0][31:0] lim_w;
  logic [NUM_RANGES-1:0]       win_hit;
  logic                        any_hit;
  logic [IDX_W-1:0]            win_idx;
  node_t                       win_node;

  dram_rr_regfile #(
    .NUM_RANGES(NUM_RANGES), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_o(base_w), .lim_o(lim_w)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    dram_rr_match u_match (
      .base_w(base_w[g]), .lim_w(lim_w[g]),
      .addr_hi(req_addr[PA_W-1:BND_LO]), .addr_ilv(req_addr[14:12]),
      .is_write(req_write), .hit(win_hit[g])
    );
  end

  dram_rr_prio #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_prio (
    .req(win_hit), .any(any_hit), .idx(win_idx)
  );

  assign win_node = lim_w[win_idx][NODE_W-1:0];

  logic unused_addr;
  assign unused_addr = ^{req_addr[BND_LO-1:15], req_addr[11:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_node  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_miss  <= req_valid && !any_hit;
      rsp_node  <= (req_valid && any_hit) ? win_node : '0;
    end
  end
endmodule

// File: rtl/dram_range_router_chk.sv
module dram_range_router_chk
  import dram_rr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int CFG_AW     = 8,
  parameter int REG_BASE   = 'h40
) (
  input logic              clk,
  input logic              rst,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [NODE_W-1:0] rsp_node
);
  localparam logic [CFG_AW:0] LO = (CFG_AW+1)'(REG_BASE);
  localparam logic [CFG_AW:0] HI = (CFG_AW+1)'(REG_BASE + NUM_RANGES*8);

  logic [CFG_AW-1:0] prev_addr;
  always_ff @(posedge clk) begin
    if (rst) prev_addr <= '0;
    else     prev_addr <= cfg_addr;
  end

  logic              prev_in;
  logic [CFG_AW-1:0] prev_off;
  assign prev_in  = ({1'b0, prev_addr} >= LO) && ({1'b0, prev_addr} < HI);
  assign prev_off = prev_addr - LO[CFG_AW-1:0];

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_node == '0));

  assert_rsp_timing_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  assert_hit_miss_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

  assert_idle_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));

  assert_miss_node_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> rsp_node == '0);

  assert_base_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (prev_in && !prev_off[2]) |-> (cfg_rdata & ~BASE_WMASK) == '0);

  assert_lim_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (prev_in && prev_off[2]) |-> (cfg_rdata & ~LIM_WMASK) == '0);

  assert_outside_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !prev_in |-> cfg_rdata == '0);
endmodule

bind dram_range_router dram_range_router_chk #(
  .NUM_RANGES(NUM_RANGES), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_node(rsp_node)
);

// File: tb/dram_range_router_test.sv
module dram_range_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_node;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_range_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_node(rsp_node)
  );

  // {write, exp_hit, exp_node, pad, address}
  localparam int NV = 17;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd1, 3'd0, 40'h00_0000_0000},  // R3 lower bound inclusive
    {1'b0, 1'b1, 3'd1, 3'd0, 40'h00_0FFF_FFFF},  // R3 upper bound inclusive
    {1'b0, 1'b1, 3'd2, 3'd0, 40'h00_1000_0000},  // R8 node from limit word
    {1'b1, 1'b0, 3'd0, 3'd0, 40'h00_1000_0000},  // R4 write to read-only window
    {1'b0, 1'b1, 3'd3, 3'd0, 40'h00_2000_1000},  // R5 code 001, A12=1
    {1'b0, 1'b1, 3'd4, 3'd0, 40'h00_2000_0000},  // R5 code 001, A12=0
    {1'b0, 1'b1, 3'd5, 3'd0, 40'h00_3000_5000},  // R5 code 011 exact
    {1'b0, 1'b1, 3'd5, 3'd0, 40'h00_3000_7000},  // R5 code 011, A13 ignored
    {1'b0, 1'b1, 3'd6, 3'd0, 40'h00_3000_3000},  // R5 code 111
    {1'b0, 1'b0, 3'd0, 3'd0, 40'h00_3000_1000},  // R5 R7 no slice owner
    {1'b0, 1'b1, 3'd1, 3'd0, 40'h00_0600_0000},  // R6 overlap, lowest wins
    {1'b1, 1'b1, 3'd7, 3'd0, 40'h00_4000_7000},  // R5 reserved code no interleave
    {1'b0, 1'b0, 3'd0, 3'd0, 40'h00_4000_0000},  // R4 read to write-only window
    {1'b0, 1'b0, 3'd0, 3'd0, 40'h00_4100_0000},  // R3 one above limit
    {1'b1, 1'b1, 3'd7, 3'd0, 40'h00_4000_0000},  // R4 write enabled
    {1'b0, 1'b0, 3'd0, 3'd0, 40'hFF_FFFF_FFFF},  // R7 top of space misses
    {1'b1, 1'b1, 3'd3, 3'd0, 40'h00_2000_1000}   // R4 write on interleaved window
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s readback 0x%0h: actual=%h expected=%h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic req_chk(input logic w, input logic [39:0] a, input logic eh,
                         input logic [2:0] en, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh || rsp_node !== en) begin
      errors++;
      $display("FAIL %s addr=%h w=%0d: actual v/h/m/node=%b%b%b/%0d expected 1%b%b/%0d",
               tag, a, w, rsp_valid, rsp_hit, rsp_miss, rsp_node, eh, !eh, en);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0 || rsp_node !== 3'd0) begin
      errors++;
      $display("FAIL R1 outputs in reset: actual %b%b%b/%0d expected 000/0",
               rsp_valid, rsp_hit, rsp_miss, rsp_node);
    end
    rst = 1'b0;
    rd_chk(8'h40, 32'h0, "R1");
    rd_chk(8'h7C, 32'h0, "R1");
    // R7 idle cycle
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle: actual %b%b%b expected 000", rsp_valid, rsp_hit, rsp_miss);
    end
    // R2 reserved bits, offsets of window 7
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    rd_chk(8'h78, 32'hFFFF_0703, "R2");
    rd_chk(8'h7C, 32'hFFFF_0707, "R2");
    rd_chk(8'h7B, 32'hFFFF_0703, "R2");
    // R9 outside window
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd_chk(8'h20, 32'h0, "R9");
    rd_chk(8'h80, 32'h0, "R9");
    rd_chk(8'h40, 32'h0, "R9");
    // program limits first, then bases
    wr(8'h44, 32'h000F_0001); wr(8'h4C, 32'h001F_0002);
    wr(8'h54, 32'h002F_0103); wr(8'h5C, 32'h002F_0004);
    wr(8'h64, 32'h003F_0505); wr(8'h6C, 32'h003F_0306);
    wr(8'h74, 32'h0008_0007); wr(8'h7C, 32'h0040_0707);
    wr(8'h40, 32'h0000_0003); wr(8'h48, 32'h0010_0001);
    wr(8'h50, 32'h0020_0103); wr(8'h58, 32'h0020_0103);
    wr(8'h60, 32'h0030_0303); wr(8'h68, 32'h0030_0703);
    wr(8'h70, 32'h0005_0003); wr(8'h78, 32'h0040_0202);
    rd_chk(8'h64, 32'h003F_0505, "R2");
    for (int i = 0; i < NV; i++) begin
      req_chk(VEC[i][47], VEC[i][39:0], VEC[i][46], VEC[i][45:43],
              $sformatf("R3/R4/R5/R6/R8 vector %0d", i));
    end
    // R6 directed: back-to-back requests, both answered one cycle later
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 40'h00_0500_0000;
    @(negedge clk);
    req_addr = 40'h00_3000_3000;
    checks++;
    if (rsp_hit !== 1'b1 || rsp_node !== 3'd1) begin
      errors++;
      $display("FAIL R6 first of pair: actual %b/%0d expected 1/1", rsp_hit, rsp_node);
    end
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_hit !== 1'b1 || rsp_node !== 3'd6) begin
      errors++;
      $display("FAIL R5 second of pair: actual %b/%0d expected 1/6", rsp_hit, rsp_node);
    end
    // R1 reset clears programmed windows
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk(8'h40, 32'h0, "R1");
    req_chk(1'b0, 40'h00_0000_0000, 1'b0, 3'd0, "R1 after reset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule